// File: doc/BRIEF.md
# Quantized 16-bit shift and byte-swap unit

This unit performs the shift and byte-swap operations of a processor whose registers are 24 bits wide but whose arithmetic width is 16 bits. One operation is issued per cycle. It selects logical right shift, arithmetic right shift, logical left shift, or a byte swap. Only the low 16 bits of the destination operand are shifted. The upper eight result bits are always cleared.

The requested shift amount comes from the low 16 bits of the source register or from a 7-bit immediate. In both cases it is quantized before use. Requests of 0 to 3 shift by exactly that count. Requests of 4 to 7 shift by 4. Any request of 8 or more shifts by 8. Software that needs a longer shift chains several operations.

The result and its N and Z flags are registered. They appear one cycle after issue and hold until the next issue.

Top module: `shsw_unit`

## Requirements
- R1: Result bits 23:16 are always zero, and bits 23:16 of rd and rs never change result bits 15:0.
- R2: A requested amount of 0, 1, 2 or 3 shifts rd bits 15:0 by exactly that many positions; amount 0 returns rd bits 15:0 unchanged.
- R3: A requested amount from 4 to 7 shifts by exactly 4 positions.
- R4: A requested amount of 8 or more (including 16, 127 and 0xFFFF) shifts by exactly 8 positions.
- R5: Operation code 2'b00 is a logical right shift that fills vacated high bits with zero.
- R6: Operation code 2'b01 is an arithmetic right shift that copies rd bit 15 into the vacated high bits.
- R7: Operation code 2'b10 is a left shift that fills vacated low bits with zero.
- R8: When amt_imm is 1 the amount is the 7-bit immediate; when 0 it is rs bits 15:0; both use the same quantization.
- R9: Operation code 2'b11 places rs bits 7:0 in result bits 15:8 and rs bits 15:8 in result bits 7:0; rd and the amount are ignored.
- R10: flag_z is 1 exactly when result bits 15:0 are zero, and flag_n equals result bit 15.
- R11: An issue in one cycle gives res_vld high with its result in the next cycle. Without an issue, res_vld is low and the result and flags hold their previous values.
- R12: During and after reset, before any issue, res_vld, result, flag_n and flag_z are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Starts an operation this cycle |
| op | input | 2 | 00 logical right, 01 arithmetic right, 10 left, 11 swap |
| amt_imm | input | 1 | 1: amount from imm_amt, 0: amount from rs_val[15:0] |
| rd_val | input | 24 | Operand to shift |
| rs_val | input | 24 | Register amount source and swap operand |
| imm_amt | input | 7 | Immediate shift amount |
| res_vld | output | 1 | Result valid, one cycle after issue |
| result | output | 24 | Registered result |
| flag_n | output | 1 | Negative flag of the result |
| flag_z | output | 1 | Zero flag of the result |

## Verification
Two functions can act in the same cycle. Sign replication of the arithmetic right shift can coincide with saturation of the amount, as when a negative operand gets a request of 16 or 0xFFFF. That request must give exactly eight copies of bit 15, not an all-ones word. The bench provokes this case and also sends back-to-back issues whose amounts fall on either side of the 3/4 and 7/8 boundaries. Each result is judged against a bench model that quantizes the amount on its own.

// File: rtl/shsw_pkg.sv
package shsw_pkg;
   typedef enum logic [1:0] {
      SHSW_SRL  = 2'b00,
      SHSW_SRA  = 2'b01,
      SHSW_SLL  = 2'b10,
      SHSW_SWAP = 2'b11
   } shsw_op_e;
endpackage

// File: rtl/shsw_amt_quant.sv
// Maps a requested amount onto the allowed shift counts {0..MID-1, MID, SAT}.
module shsw_amt_quant #(
   parameter int SRC_W   = 16,
   parameter int CNT_W   = 4,
   parameter int MID_CNT = 4,
   parameter int SAT_CNT = 8
) (
   input  logic [SRC_W-1:0] amt,
   output logic [CNT_W-1:0] cnt
);
   if (MID_CNT >= SAT_CNT) begin : g_bad_order
      $error("shsw_amt_quant: MID_CNT must be below SAT_CNT");
   end
   if (SAT_CNT >= (1 << CNT_W)) begin : g_bad_cnt
      $error("shsw_amt_quant: CNT_W too narrow for SAT_CNT");
   end
   if (SRC_W < CNT_W) begin : g_bad_src
      $error("shsw_amt_quant: SRC_W narrower than CNT_W");
   end

   always_comb begin
      if (amt >= SRC_W'(SAT_CNT))
         cnt = CNT_W'(SAT_CNT);
      else if (amt >= SRC_W'(MID_CNT))
         cnt = CNT_W'(MID_CNT);
      else
         cnt = amt[CNT_W-1:0];
   end
endmodule

// File: rtl/shsw_shifter.sv
// Log-depth barrel shifter, one stage per count bit.
module shsw_shifter #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 4
) (
   input  logic [DATA_W-1:0] din,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              left,
   input  logic              arith,
   output logic [DATA_W-1:0] dout
);
   if ((1 << (CNT_W - 1)) >= DATA_W) begin : g_bad_depth
      $error("shsw_shifter: top stage would exceed the data width");
   end

   logic              fill;
   logic [DATA_W-1:0] stage [CNT_W+1];

   assign fill     = arith & din[DATA_W-1];
   assign stage[0] = din;

   for (genvar i = 0; i < CNT_W; i++) begin : g_stage
      localparam int SH = 1 << i;
      logic [DATA_W-1:0] fill_mask;
      logic [DATA_W-1:0] shifted;
      assign fill_mask  = fill ? ~({DATA_W{1'b1}} >> SH) : '0;
      assign shifted    = left ? (stage[i] << SH) : ((stage[i] >> SH) | fill_mask);
      assign stage[i+1] = cnt[i] ? shifted : stage[i];
   end

   assign dout = stage[CNT_W];
endmodule

// File: rtl/shsw_swap.sv
module shsw_swap #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int HALF = DATA_W / 2;
   if ((DATA_W % 2) != 0) begin : g_bad_width
      $error("shsw_swap: DATA_W must be even");
   end
   assign dout = {din[HALF-1:0], din[DATA_W-1:HALF]};
endmodule

// File: rtl/shsw_unit.sv
module shsw_unit #(
   parameter int REG_W       = 24,
   parameter int DATA_W      = 16,
   parameter int IMM_W       = 7,
   parameter int MID_CNT     = 4,
   parameter int SAT_CNT     = 8,
   parameter bit SHARE_QUANT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [1:0]        op,
   input  logic              amt_imm,
   input  logic [REG_W-1:0]  rd_val,
   input  logic [REG_W-1:0]  rs_val,
   input  logic [IMM_W-1:0]  imm_amt,
   output logic              res_vld,
   output logic [REG_W-1:0]  result,
   output logic              flag_n,
   output logic              flag_z
);
   import shsw_pkg::*;

   localparam int CNT_W = $clog2(SAT_CNT + 1);
   localparam int PAD_W = REG_W - DATA_W;

   if (REG_W <= DATA_W) begin : g_bad_reg
      $error("shsw_unit: REG_W must exceed DATA_W");
   end
   if (IMM_W > DATA_W) begin : g_bad_imm
      $error("shsw_unit: IMM_W must not exceed DATA_W");
   end

   shsw_op_e          op_e;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sh_out;
   logic [DATA_W-1:0] sw_out;
   logic [DATA_W-1:0] nxt_low;
   logic              unused_hi;

   assign op_e      = shsw_op_e'(op);
   assign unused_hi = ^{rd_val[REG_W-1:DATA_W], rs_val[REG_W-1:DATA_W]};

   if (SHARE_QUANT) begin : g_quant_shared
      logic [DATA_W-1:0] amt_sel;
      assign amt_sel = amt_imm ? DATA_W'(imm_amt) : rs_val[DATA_W-1:0];
      shsw_amt_quant #(.SRC_W(DATA_W), .CNT_W(CNT_W), .MID_CNT(MID_CNT), .SAT_CNT(SAT_CNT))
         i_quant (.amt(amt_sel), .cnt(cnt));
   end else begin : g_quant_split
      logic [CNT_W-1:0] cnt_reg;
      logic [CNT_W-1:0] cnt_imm;
      shsw_amt_quant #(.SRC_W(DATA_W), .CNT_W(CNT_W), .MID_CNT(MID_CNT), .SAT_CNT(SAT_CNT))
         i_quant_reg (.amt(rs_val[DATA_W-1:0]), .cnt(cnt_reg));
      shsw_amt_quant #(.SRC_W(IMM_W), .CNT_W(CNT_W), .MID_CNT(MID_CNT), .SAT_CNT(SAT_CNT))
         i_quant_imm (.amt(imm_amt), .cnt(cnt_imm));
      assign cnt = amt_imm ? cnt_imm : cnt_reg;
   end

   shsw_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_shifter (
      .din   (rd_val[DATA_W-1:0]),
      .cnt   (cnt),
      .left  (op_e == SHSW_SLL),
      .arith (op_e == SHSW_SRA),
      .dout  (sh_out)
   );

   shsw_swap #(.DATA_W(DATA_W)) i_swap (
      .din  (rs_val[DATA_W-1:0]),
      .dout (sw_out)
   );

   assign nxt_low = (op_e == SHSW_SWAP) ? sw_out : sh_out;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld <= 1'b0;
         result  <= '0;
         flag_n  <= 1'b0;
         flag_z  <= 1'b0;
      end else begin
         res_vld <= issue;
         if (issue) begin
            result <= {{PAD_W{1'b0}}, nxt_low};
            flag_n <= nxt_low[DATA_W-1];
            flag_z <= (nxt_low == '0);
         end
      end
   end
endmodule

// File: rtl/shsw_unit_chk.sv
module shsw_unit_chk #(
   parameter int REG_W  = 24,
   parameter int DATA_W = 16,
   parameter int IMM_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue,
   input logic [1:0]        op,
   input logic              amt_imm,
   input logic [REG_W-1:0]  rd_val,
   input logic [REG_W-1:0]  rs_val,
   input logic [IMM_W-1:0]  imm_amt,
   input logic              res_vld,
   input logic [REG_W-1:0]  result,
   input logic              flag_n,
   input logic              flag_z
);
   localparam int HALF = DATA_W / 2;

   logic amt_is_zero;
   assign amt_is_zero = amt_imm ? (imm_amt == '0) : (rs_val[DATA_W-1:0] == '0);

   assert_high_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> (result[REG_W-1:DATA_W] == '0));

   assert_zero_amount_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op != 2'b11 && amt_is_zero) |=> (result[DATA_W-1:0] == $past(rd_val[DATA_W-1:0])));

   assert_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op == 2'b11) |=>
         (result[DATA_W-1:0] == {$past(rs_val[HALF-1:0]), $past(rs_val[DATA_W-1:HALF])}));

   assert_neg_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> (flag_n == result[DATA_W-1]));

   assert_zero_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> (flag_z == (result[DATA_W-1:0] == '0)));

   assert_issue_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> res_vld);

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> (!res_vld && $stable(result) && $stable(flag_n) && $stable(flag_z)));
endmodule

bind shsw_unit shsw_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W), .IMM_W(IMM_W)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .issue   (issue),
   .op      (op),
   .amt_imm (amt_imm),
   .rd_val  (rd_val),
   .rs_val  (rs_val),
   .imm_amt (imm_amt),
   .res_vld (res_vld),
   .result  (result),
   .flag_n  (flag_n),
   .flag_z  (flag_z)
);

// File: tb/test_shsw_unit.sv
`timescale 1ns/1ps
module test_shsw_unit;
   localparam real CLK_NS = 20.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue = 1'b0;
   logic [1:0]  op = 2'b00;
   logic        amt_imm = 1'b0;
   logic [23:0] rd_val = '0;
   logic [23:0] rs_val = '0;
   logic [6:0]  imm_amt = '0;
   logic        res_vld;
   logic [23:0] result;
   logic        flag_n;
   logic        flag_z;

   int checks = 0;
   int errors = 0;

   always #(CLK_NS / 2.0) clk = ~clk;

   shsw_unit i_shsw_unit (
      .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .amt_imm(amt_imm),
      .rd_val(rd_val), .rs_val(rs_val), .imm_amt(imm_amt),
      .res_vld(res_vld), .result(result), .flag_n(flag_n), .flag_z(flag_z)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [23:0] model(input logic [1:0] o, input logic im,
                                         input logic [23:0] rd, input logic [23:0] rs,
                                         input logic [6:0] imm);
      logic [15:0] amt;
      int n;
      logic [15:0] r;
      amt = im ? {9'd0, imm} : rs[15:0];
      n = (amt >= 16'd8) ? 8 : (amt >= 16'd4) ? 4 : int'(amt);
      case (o)
         2'b00: r = rd[15:0] >> n;
         2'b01: r = 16'($signed(rd[15:0]) >>> n);
         2'b10: r = rd[15:0] << n;
         default: r = {rs[7:0], rs[15:8]};
      endcase
      return {8'h00, r};
   endfunction

   task automatic do_op(input string req, input logic [1:0] o, input logic im,
                        input logic [23:0] rd, input logic [23:0] rs, input logic [6:0] imm);
      logic [23:0] e;
      e = model(o, im, rd, rs, imm);
      op = o; amt_imm = im; rd_val = rd; rs_val = rs; imm_amt = imm; issue = 1'b1;
      @(negedge clk);
      issue = 1'b0;
      chk(req, "result", 32'(result), 32'(e));
      chk(req, "res_vld", 32'(res_vld), 32'd1);
   endtask

   task automatic t_reset;
      chk("R12", "res_vld", 32'(res_vld), 32'd0);
      chk("R12", "result", 32'(result), 32'd0);
      chk("R12", "flags", {30'd0, flag_n, flag_z}, 32'd0);
   endtask

   task automatic t_exact;
      do_op("R2", 2'b00, 1'b0, 24'h00_F0F0, 24'h00_0000, 7'd0);
      chk("R2", "amount 0", 32'(result), 32'h0000_F0F0);
      for (int a = 1; a <= 3; a++) do_op("R2", 2'b00, 1'b0, 24'h00_8001, 24'(a), 7'd0);
      do_op("R2", 2'b10, 1'b1, 24'h00_1234, 24'h0, 7'd3);
   endtask

   task automatic t_mid;
      for (int a = 4; a <= 7; a++) do_op("R3", 2'b00, 1'b1, 24'h00_FFFF, 24'h0, 7'(a));
      do_op("R3", 2'b10, 1'b0, 24'h00_ABCD, 24'h00_0007, 7'd0);
      chk("R3", "left by 4", 32'(result), 32'h0000_BCD0);
   endtask

   task automatic t_sat;
      do_op("R4", 2'b00, 1'b0, 24'h00_ABCD, 24'h00_0008, 7'd0);
      do_op("R4", 2'b00, 1'b0, 24'h00_ABCD, 24'h00_0010, 7'd0);
      chk("R4", "16 gives 8", 32'(result), 32'h0000_00AB);
      do_op("R4", 2'b10, 1'b0, 24'h00_ABCD, 24'h00_FFFF, 7'd0);
      do_op("R4", 2'b00, 1'b1, 24'h00_ABCD, 24'h0, 7'd127);
   endtask

   task automatic t_fill;
      do_op("R5", 2'b00, 1'b0, 24'h00_8000, 24'h00_0003, 7'd0);
      chk("R5", "zero fill", 32'(result), 32'h0000_1000);
      do_op("R6", 2'b01, 1'b0, 24'h00_8000, 24'h00_0003, 7'd0);
      chk("R6", "sign fill", 32'(result), 32'h0000_F000);
      do_op("R6", 2'b01, 1'b0, 24'h00_8100, 24'h00_FFFF, 7'd0);
      chk("R6", "saturated sign", 32'(result), 32'h0000_FF81);
      do_op("R6", 2'b01, 1'b1, 24'h00_7FF0, 24'h0, 7'd5);
      do_op("R7", 2'b10, 1'b1, 24'h00_FFFF, 24'h0, 7'd2);
      chk("R7", "low zero fill", 32'(result), 32'h0000_FFFC);
   endtask

   task automatic t_srcsel;
      do_op("R8", 2'b00, 1'b1, 24'h00_F000, 24'h00_0008, 7'd1);
      chk("R8", "imm source", 32'(result), 32'h0000_7800);
      do_op("R8", 2'b00, 1'b0, 24'h00_F000, 24'hFF_0001, 7'd8);
      chk("R8", "rs source, rs high ignored", 32'(result), 32'h0000_7800);
   endtask

   task automatic t_high;
      do_op("R1", 2'b10, 1'b1, 24'hFF_FFFF, 24'hFF_0000, 7'd8);
      chk("R1", "high cleared", 32'(result), 32'h0000_FF00);
      do_op("R1", 2'b01, 1'b1, 24'h7F_0000, 24'h0, 7'd0);
      chk("R1", "rd high ignored", 32'(result), 32'h0000_0000);
   endtask

   task automatic t_swap;
      do_op("R9", 2'b11, 1'b1, 24'hFF_FFFF, 24'hEE_12AB, 7'd9);
      chk("R9", "swap", 32'(result), 32'h0000_AB12);
      do_op("R9", 2'b11, 1'b0, 24'h00_0000, 24'h00_00FF, 7'd0);
   endtask

   task automatic t_flags;
      do_op("R10", 2'b00, 1'b0, 24'h00_0080, 24'h00_0009, 7'd0);
      chk("R10", "Z set", {30'd0, flag_n, flag_z}, 32'd1);
      do_op("R10", 2'b11, 1'b1, 24'h0, 24'h00_0080, 7'd0);
      chk("R10", "N set", {30'd0, flag_n, flag_z}, 32'd2);
      do_op("R10", 2'b00, 1'b1, 24'h00_0100, 24'h0, 7'd1);
      chk("R10", "both clear", {30'd0, flag_n, flag_z}, 32'd0);
   endtask

   task automatic t_hold;
      logic [23:0] prev;
      do_op("R11", 2'b10, 1'b1, 24'h00_0F0F, 24'h0, 7'd4);
      prev = result;
      rd_val = 24'h00_FFFF; rs_val = 24'h00_0000; op = 2'b11;
      @(negedge clk);
      chk("R11", "vld low idle", 32'(res_vld), 32'd0);
      @(negedge clk);
      chk("R11", "result held", 32'(result), 32'(prev));
      chk("R11", "flags held", {30'd0, flag_n, flag_z}, 32'd2);
   endtask

   initial begin
      #(CLK_NS * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_exact();
      t_mid();
      t_sat();
      t_fill();
      t_srcsel();
      t_high();
      t_swap();
      t_flags();
      t_hold();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule